// File: doc/BRIEF.md
# Boot Checkpoint Display Sequencer

This block watches a simple I/O write strobe for byte writes to one fixed port address, which defaults to 80h. Each byte written there is latched and shown as two hexadecimal digits on a pair of seven-segment patterns. Firmware writes a new progress code at the start of each start-up step. If the machine hangs, the display keeps the last code it received, so the display shows how far start-up got.

Some memory failures need more than one byte of detail. For these, a separate detail-load strobe supplies a checkpoint code and a 16-bit failure bitmap, in which bit n set means line or bit n failed. After a detail load the display rotates through three items without end: the code, then the bitmap's upper byte, then its lower byte, and then the code again. Each item stays up for a number of clock cycles set by a parameter. A new write to the port ends the rotation.

Top module: `postcode_display`

## Requirements
- R1: A cycle with `busWr` high and `busAddr` equal to `PORT_ADDR` (default 16'h0080) loads `busData` into the display, and the segments show it from the next cycle.
- R2: A write strobe with any other address leaves the display unchanged.
- R3: When no write and no detail load arrives and the rotation is off, the displayed value holds indefinitely.
- R4: After reset the display shows 00h and the rotation is off, so the value stays 00h until a write arrives.
- R5: A cycle with `detLoad` high captures `detCode` and `detMap`. The code is shown for exactly `DWELL` cycles, starting on the next cycle.
- R6: After the code, the rotation shows `detMap[15:8]` for `DWELL` cycles and then `detMap[7:0]` for `DWELL` cycles. It then returns to the code and repeats this order without end.
- R7: A port write during the rotation stops it. The written byte is shown and held from the next cycle on.
- R8: If a port write and a detail load arrive in the same cycle, the port write wins and the rotation stays off.
- R9: A detail load during the rotation restarts it at the code phase with the newly loaded values.
- R10: `segHi` shows the upper nibble and `segLo` the lower nibble. Segments are active high, with bit 0 = a up to bit 6 = g. The digits 0..F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (16) | I/O write address |
| busData | input | 8 | I/O write data byte |
| busWr | input | 1 | Write strobe, one cycle per write |
| detLoad | input | 1 | Load strobe for the detail rotation |
| detCode | input | 8 | Checkpoint code for the rotation |
| detMap | input | 16 | Failure bitmap for the rotation |
| segHi | output | 7 | Segment pattern for the upper-nibble digit |
| segLo | output | 7 | Segment pattern for the lower-nibble digit |

## Verification
The assertions assume that the write and detail-load strobes are sampled as clean one-cycle levels at the clock edge. They also assume `DWELL` is at least one, so every phase lasts a whole number of cycles. The bench changes every input on the falling edge only, and it runs with a dwell of three cycles. This keeps complete rotations short enough to walk through cycle by cycle. All 256 data bytes and a dense sweep of non-matching addresses are applied through the normal write strobe. Collisions and mid-rotation loads are placed at known phase offsets.

// File: rtl/postdisp_pkg.sv
package postdisp_pkg;

  typedef enum logic [1:0] {
    PH_CODE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  typedef struct packed {
    logic takePort;
    logic takeDetail;
    logic showCode;
    logic showHigh;
    logic showLow;
  } dpCtrl_t;

  function automatic phase_e nextPhase(input phase_e p);
    case (p)
      PH_CODE: return PH_HIGH;
      PH_HIGH: return PH_LOW;
      default: return PH_CODE;
    endcase
  endfunction

  function automatic logic [6:0] hexToSeg(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F;
      4'h1: return 7'h06;
      4'h2: return 7'h5B;
      4'h3: return 7'h4F;
      4'h4: return 7'h66;
      4'h5: return 7'h6D;
      4'h6: return 7'h7D;
      4'h7: return 7'h07;
      4'h8: return 7'h7F;
      4'h9: return 7'h6F;
      4'hA: return 7'h77;
      4'hB: return 7'h7C;
      4'hC: return 7'h39;
      4'hD: return 7'h5E;
      4'hE: return 7'h79;
      default: return 7'h71;
    endcase
  endfunction

endpackage

// File: rtl/postdisp_ctrl.sv
module postdisp_ctrl
  import postdisp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_ADDR = 'h80,
  parameter int DWELL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              detLoad,
  output dpCtrl_t           ctrl
);

  localparam int CNT_W = $clog2(DWELL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

  logic portHit;
  logic detailOn;
  phase_e phase;
  logic [CNT_W-1:0] cnt;

  assign portHit = busWr && (busAddr == MATCH);

  always_comb begin
    ctrl = '0;
    if (portHit) begin
      ctrl.takePort = 1'b1;
    end else if (detLoad) begin
      ctrl.takeDetail = 1'b1;
    end else if (detailOn && cnt == LAST) begin
      case (phase)
        PH_CODE: ctrl.showHigh = 1'b1;
        PH_HIGH: ctrl.showLow  = 1'b1;
        default: ctrl.showCode = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detailOn <= 1'b0;
      phase    <= PH_CODE;
      cnt      <= '0;
    end else if (portHit) begin
      detailOn <= 1'b0;
      phase    <= PH_CODE;
      cnt      <= '0;
    end else if (detLoad) begin
      detailOn <= 1'b1;
      phase    <= PH_CODE;
      cnt      <= '0;
    end else if (detailOn) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        phase <= nextPhase(phase);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    detailOn |-> cnt <= LAST);

  // R6
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (detailOn && !portHit && !detLoad && cnt == LAST) |=> phase == nextPhase($past(phase)));

  // R7
  cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    portHit |=> !detailOn);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (detLoad && !portHit) |=> (detailOn && phase == PH_CODE && cnt == '0));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrl));

endmodule

// File: rtl/postdisp_datapath.sv
module postdisp_datapath
  import postdisp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtrl_t     ctrl,
  input  logic [7:0]  busData,
  input  logic [7:0]  detCode,
  input  logic [15:0] detMap,
  output logic [7:0]  shownByte
);

  logic [7:0]  codeReg;
  logic [15:0] mapReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shownByte <= 8'h00;
      codeReg   <= 8'h00;
      mapReg    <= 16'h0000;
    end else begin
      if (ctrl.takeDetail) begin
        codeReg <= detCode;
        mapReg  <= detMap;
      end
      if (ctrl.takePort)        shownByte <= busData;
      else if (ctrl.takeDetail) shownByte <= detCode;
      else if (ctrl.showCode)   shownByte <= codeReg;
      else if (ctrl.showHigh)   shownByte <= mapReg[15:8];
      else if (ctrl.showLow)    shownByte <= mapReg[7:0];
    end
  end

  // R1
  port_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.takePort |=> shownByte == $past(busData));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl == '0) |=> $stable(shownByte));

  // R5
  detail_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.takeDetail |=> shownByte == $past(detCode));

endmodule

// File: rtl/postcode_display.sv
module postcode_display
  import postdisp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PORT_ADDR = 'h80,
  parameter int DWELL = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  logic              busWr,
  input  logic              detLoad,
  input  logic [7:0]        detCode,
  input  logic [15:0]       detMap,
  output logic [6:0]        segHi,
  output logic [6:0]        segLo
);

  dpCtrl_t ctrl;
  logic [7:0] shownByte;

  postdisp_ctrl #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .DWELL(DWELL)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .detLoad(detLoad), .ctrl(ctrl)
  );

  postdisp_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busData(busData),
    .detCode(detCode), .detMap(detMap), .shownByte(shownByte)
  );

  assign segHi = hexToSeg(shownByte[7:4]);
  assign segLo = hexToSeg(shownByte[3:0]);

  // R2
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr != ADDR_W'(PORT_ADDR) && !detLoad && ctrl == '0) |=> $stable(shownByte));

endmodule

// File: tb/test_postcode_display.sv
`timescale 1ns/1ps
module test_postcode_display;

  localparam int DW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic busWr = 1'b0;
  logic detLoad = 1'b0;
  logic [7:0] detCode = '0;
  logic [15:0] detMap = '0;
  logic [6:0] segHi, segLo;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  postcode_display #(.ADDR_W(16), .PORT_ADDR('h80), .DWELL(DW)) i_postcode_display (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .busWr(busWr),
    .detLoad(detLoad), .detCode(detCode), .detMap(detMap), .segHi(segHi), .segLo(segLo)
  );

  function automatic logic [6:0] refSeg(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  function automatic logic [7:0] rotItem(input logic [7:0] c, input logic [15:0] m, input int j);
    case ((j / DW) % 3)
      0: return c;
      1: return m[15:8];
      default: return m[7:0];
    endcase
  endfunction

  task automatic expectByte(input logic [7:0] exp, input string req);
    logic [13:0] want;
    want = {refSeg(exp[7:4]), refSeg(exp[3:0])};
    checks++;
    if ({segHi, segLo} !== want) begin
      failures++;
      $display("FAIL %s: segs=%h_%h expected=%h_%h (byte %h)", req, segHi, segLo,
               want[13:7], want[6:0], exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic portWrite(input logic [15:0] a, input logic [7:0] d);
    busAddr = a; busData = d; busWr = 1'b1;
    step();
    busWr = 1'b0;
  endtask

  task automatic loadDetail(input logic [7:0] c, input logic [15:0] m);
    detCode = c; detMap = m; detLoad = 1'b1;
    step();
    detLoad = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rstN = 1'b1;
    // R4: reset value and no rotation afterwards
    expectByte(8'h00, "R4");
    for (int i = 0; i < 3 * DW + 2; i++) begin
      step();
      expectByte(8'h00, "R4");
    end

    // R1 R10: every byte value through the port
    for (int b = 0; b < 256; b++) begin
      portWrite(16'h0080, 8'(b));
      expectByte(8'(b), "R1/R10");
    end

    // R2: foreign addresses ignored
    portWrite(16'h0080, 8'h5A);
    for (int lo = 0; lo < 256; lo++) begin
      if (lo != 'h80) begin
        portWrite({8'h00, 8'(lo)}, 8'(lo ^ 8'hFF));
        expectByte(8'h5A, "R2");
      end
    end
    for (int hi = 1; hi < 256; hi++) begin
      portWrite({8'(hi), 8'h80}, 8'(hi));
      expectByte(8'h5A, "R2");
    end

    // R3: hold with no activity
    for (int i = 0; i < 20; i++) begin
      step();
      expectByte(8'h5A, "R3");
    end

    // R5 R6: two full rotations
    loadDetail(8'h2E, 16'h1020);
    expectByte(8'h2E, "R5");
    for (int j = 1; j < 6 * DW; j++) begin
      step();
      expectByte(rotItem(8'h2E, 16'h1020, j), "R6");
    end

    // R7: port write mid-rotation cancels
    step();
    portWrite(16'h0080, 8'hC3);
    expectByte(8'hC3, "R7");
    for (int i = 0; i < 6 * DW; i++) begin
      step();
      expectByte(8'hC3, "R7");
    end

    // R8: same-cycle collision, port wins
    busAddr = 16'h0080; busData = 8'h44; busWr = 1'b1;
    detCode = 8'h2C; detMap = 16'h0002; detLoad = 1'b1;
    step();
    busWr = 1'b0; detLoad = 1'b0;
    expectByte(8'h44, "R8");
    for (int i = 0; i < 4 * DW; i++) begin
      step();
      expectByte(8'h44, "R8");
    end

    // R9: reload during rotation restarts at code
    loadDetail(8'h30, 16'hABCD);
    for (int i = 0; i < DW + 1; i++) step();
    expectByte(8'hAB, "R9");
    loadDetail(8'h2C, 16'h0002);
    expectByte(8'h2C, "R9");
    for (int j = 1; j < 3 * DW + 1; j++) begin
      step();
      expectByte(rotItem(8'h2C, 16'h0002, j), "R9");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule